// File: doc/BRIEF.md
# Coil Link Phase-Slotted Serializer

This block is the digital half of a vertical chip-to-chip link carried by stacked, non-contact coils. The sending side splits a wide parallel word into 8-bit slices and puts one slice per cycle on eight data coils. A separate marker coil tells the receiver where a frame starts. The receiving side puts the slices back together into a word of the same width.

There is no handshake on the link. Each chip has a free-running phase counter, and the transmit and receive strobes are decoded from that counter. A frame takes one cycle per slice, followed by one idle turnaround cycle. The receive strobe is the transmit strobe delayed by a fixed number of cycles, which covers the flight time across the link.

The coil port has three modes: transmit, receive and idle. A mode request takes effect after one clock. The coil drivers and sense amplifiers are modelled as plain wires, so two instances wired back to back form a complete link.

Top module: `coil_link_serdes`

## Requirements
- R1: With SLICES = WORD_W/LANES (LANES = 8 by default), the phase counter is 0 in the first cycle after reset and counts modulo SLICES+1. `tx_en_o` is high when the phase is below SLICES and low in the single turnaround phase.
- R2: The mode code on `mode_req` is 2'b00 idle, 2'b01 transmit, 2'b10 receive, and 2'b11 is treated as idle. `mode_o` shows the decoded mode exactly one cycle after the request and is idle after reset.
- R3: In transmit mode, the word on `tx_word` is sampled at the edge that ends phase 0, and `tx_take` pulses in the cycle that follows. From that cycle on, `coil_data_o` carries slice 0, then slice 1, and so on, one per cycle, where slice k is bits [8k+7:8k]. `coil_clk_o` is high only together with slice 0. A change to `tx_word` after sampling does not alter the frame in flight.
- R4: In the cycle after a turnaround phase, `coil_data_o` is zero and `coil_clk_o` is low.
- R5: `rx_en_o` equals `tx_en_o` delayed by exactly RX_LAT cycles, with 1 <= RX_LAT <= SLICES. The receive slice index is the phase minus RX_LAT, modulo SLICES+1.
- R6: In receive mode, when `rx_en_o` is high, the input slice is stored at the receive slice index. When the final slice is stored in a framed word, `rx_word` is updated and `rx_valid` pulses for exactly one cycle. With RX_LAT = 2 and one link register, `rx_valid` appears in phase (SLICES+RX_LAT) mod (SLICES+1).
- R7: A received frame is delivered only if `coil_clk_i` is high when slice 0 is stored. A frame without that marker gives no `rx_valid`, and `rx_word` keeps its previous value.
- R8: While `mode_o` is not transmit, in the following cycle `coil_data_o` is zero and `coil_clk_o` and `tx_take` are low.
- R9: While `mode_o` is not receive, incoming coil data is ignored: `rx_valid` stays low and `rx_word` is unchanged.
- R10: If the mode leaves transmit in the middle of a frame, the slice already chosen at that edge still goes out, and the data outputs are zero from the next cycle. If the mode enters transmit in the middle of a frame, nothing is driven until the next phase 0.
- R11: With one instance transmitting and another receiving over a registered link, every sent word arrives unchanged, in order, exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock shared by the stack |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested port mode code |
| mode_o | output | 2 | Mode now in force |
| tx_word | input | WORD_W | Parallel word to send |
| tx_take | output | 1 | Pulse: a word was sampled for sending |
| coil_data_o | output | LANES | Data to the transmit coils |
| coil_clk_o | output | 1 | Frame marker to the clock coil |
| coil_data_i | input | LANES | Data from the receive coils |
| coil_clk_i | input | 1 | Frame marker from the clock coil |
| tx_en_o | output | 1 | Transmit slot strobe from the phase decode |
| rx_en_o | output | 1 | Receive slot strobe from the phase decode |
| rx_word | output | WORD_W | Last reassembled word |
| rx_valid | output | 1 | Pulse: `rx_word` was just updated |

## Verification
Two instances are wired back to back through one register stage. They exchange an all-zero word, an all-ones word, an alternating-bit word, a byte-ramp word and random words. The ramp word shows whether slices come out in the wrong order. The alternating and all-ones words show a lane that is stuck or swapped, and the all-zero word would hide a missing frame if arrivals were not counted.

Frames are also sent with the marker masked, and with the receiving side idle or transmitting. These cases separate marker gating from mode gating. Mode changes in the middle of a frame, in both directions, test the one-cycle switch against the frame boundary.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic [1:0] {
    LM_IDLE = 2'b00,
    LM_TX   = 2'b01,
    LM_RX   = 2'b10
  } lnk_mode_e;

  // Unused code 2'b11 falls back to idle.
  function automatic lnk_mode_e lnk_mode_decode(input logic [1:0] code);
    case (code)
      2'b01:   return LM_TX;
      2'b10:   return LM_RX;
      default: return LM_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lnk_mode_ctrl.sv
module lnk_mode_ctrl
  import lnk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  output lnk_mode_e  mode_q
);

  // Single register stage: a request takes effect at the next edge.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= LM_IDLE;
    else     mode_q <= lnk_mode_decode(mode_req);
  end

endmodule

// File: rtl/lnk_phase_ctrl.sv
module lnk_phase_ctrl #(
  parameter  int SLICES = 4,
  parameter  int RX_LAT = 2,
  localparam int PERIOD = SLICES + 1,
  localparam int PW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          tx_slot,
  output logic          rx_slot,
  output logic [PW-1:0] rx_idx
);

  localparam logic [PW-1:0] LAST_PH = PW'(PERIOD - 1);
  localparam logic [PW-1:0] NSLICE  = PW'(SLICES);
  localparam logic [PW:0]   PER_W   = (PW+1)'(PERIOD);
  localparam logic [PW:0]   OFS_W   = (PW+1)'(PERIOD - RX_LAT);

  logic [PW:0] shifted;

  // Free-running frame counter, no handshake.
  always_ff @(posedge clk) begin
    if (rst)                  phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  // Phase seen RX_LAT cycles ago, wrapped into the frame.
  always_comb begin
    shifted = {1'b0, phase} + OFS_W;
    if (shifted >= PER_W) shifted = shifted - PER_W;
  end

  assign rx_idx  = shifted[PW-1:0];
  assign tx_slot = (phase < NSLICE);
  assign rx_slot = (rx_idx < NSLICE);

endmodule

// File: rtl/lnk_tx_mux.sv
module lnk_tx_mux #(
  parameter  int LANES  = 8,
  parameter  int SLICES = 4,
  localparam int W      = LANES * SLICES,
  localparam int PW     = $clog2(SLICES + 1),
  localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_tx,
  input  logic [PW-1:0]    phase,
  input  logic             tx_slot,
  input  logic [W-1:0]     word,
  output logic [LANES-1:0] data_o,
  output logic             mark_o
);

  logic             start;
  logic             active_q;
  logic             drive;
  logic [W-1:0]     hold_q;
  logic [W-1:0]     src;
  logic [LANES-1:0] slc [SLICES];

  assign start = is_tx && (phase == '0);
  assign drive = is_tx && tx_slot && (start || active_q);
  // Slice 0 goes straight from the input; later slices from the held copy.
  assign src   = start ? word : hold_q;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    assign slc[g] = src[g*LANES +: LANES];
  end

  always_ff @(posedge clk) begin
    if (start) hold_q <= word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      data_o   <= '0;
      mark_o   <= 1'b0;
    end else begin
      active_q <= is_tx && (start || active_q);
      data_o   <= drive ? slc[phase[SW-1:0]] : '0;
      mark_o   <= start;
    end
  end

endmodule

// File: rtl/lnk_rx_demux.sv
module lnk_rx_demux #(
  parameter  int LANES  = 8,
  parameter  int SLICES = 4,
  localparam int W      = LANES * SLICES,
  localparam int PW     = $clog2(SLICES + 1),
  localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_rx,
  input  logic             rx_slot,
  input  logic [PW-1:0]    rx_idx,
  input  logic [LANES-1:0] data_i,
  input  logic             mark_i,
  output logic [W-1:0]     word_o,
  output logic             valid_o
);

  localparam logic [PW-1:0] FINAL = PW'(SLICES - 1);

  logic [LANES-1:0] asm_q [SLICES];
  logic             framed_q;
  logic             frame_ok;
  logic             take;
  logic [W-1:0]     full;

  assign take     = is_rx && rx_slot;
  // Slice 0 must come with the marker; later slices inherit that verdict.
  assign frame_ok = (rx_idx == '0) ? mark_i : framed_q;

  for (genvar g = 0; g < SLICES; g++) begin : g_join
    if (g == SLICES - 1) begin : g_top
      assign full[g*LANES +: LANES] = data_i;
    end else begin : g_low
      assign full[g*LANES +: LANES] = asm_q[g];
    end
  end

  // Assembly store without reset, one write port.
  always_ff @(posedge clk) begin
    if (take) asm_q[rx_idx[SW-1:0]] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      framed_q <= 1'b0;
      valid_o  <= 1'b0;
      word_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!is_rx) begin
        framed_q <= 1'b0;
      end else if (take) begin
        framed_q <= frame_ok;
        if ((rx_idx == FINAL) && frame_ok) begin
          word_o  <= full;
          valid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/coil_link_serdes.sv
module coil_link_serdes
  import lnk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 8,
  parameter int RX_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_req,
  output logic [1:0]        mode_o,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_take,
  output logic [LANES-1:0]  coil_data_o,
  output logic              coil_clk_o,
  input  logic [LANES-1:0]  coil_data_i,
  input  logic              coil_clk_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int SLICES = WORD_W / LANES;
  localparam int PW     = $clog2(SLICES + 1);

  lnk_mode_e      mode_q;
  logic [PW-1:0]  phase;
  logic [PW-1:0]  rx_idx;
  logic           tx_slot;
  logic           rx_slot;
  logic           mark_q;

  lnk_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_req (mode_req),
    .mode_q   (mode_q)
  );

  lnk_phase_ctrl #(.SLICES(SLICES), .RX_LAT(RX_LAT)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .tx_slot (tx_slot),
    .rx_slot (rx_slot),
    .rx_idx  (rx_idx)
  );

  lnk_tx_mux #(.LANES(LANES), .SLICES(SLICES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .is_tx   (mode_q == LM_TX),
    .phase   (phase),
    .tx_slot (tx_slot),
    .word    (tx_word),
    .data_o  (coil_data_o),
    .mark_o  (mark_q)
  );

  lnk_rx_demux #(.LANES(LANES), .SLICES(SLICES)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .is_rx   (mode_q == LM_RX),
    .rx_slot (rx_slot),
    .rx_idx  (rx_idx),
    .data_i  (coil_data_i),
    .mark_i  (coil_clk_i),
    .word_o  (rx_word),
    .valid_o (rx_valid)
  );

  assign mode_o     = mode_q;
  assign coil_clk_o = mark_q;
  assign tx_take    = mark_q;
  assign tx_en_o    = tx_slot;
  assign rx_en_o    = rx_slot;

endmodule

// File: rtl/coil_link_serdes_chk.sv
module coil_link_serdes_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_req,
  input logic [1:0]       mode_o,
  input logic             tx_take,
  input logic [LANES-1:0] coil_data_o,
  input logic             coil_clk_o,
  input logic             tx_en_o,
  input logic             rx_en_o,
  input logic             rx_valid
);

  p_mode_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_o == (($past(mode_req) == 2'b11) ? 2'b00 : $past(mode_req))));

  p_marker_slot_r3: assert property (@(posedge clk) disable iff (rst)
    coil_clk_o |-> $past(tx_en_o));

  p_marker_once_r3: assert property (@(posedge clk) disable iff (rst)
    coil_clk_o |=> !coil_clk_o);

  p_turnaround_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tx_en_o)) |-> (coil_data_o == '0 && !coil_clk_o));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_o) != 2'b01) |-> (coil_data_o == '0 && !coil_clk_o && !tx_take));

  p_rx_gate_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(mode_o) == 2'b10 && $past(rx_en_o)));

endmodule

bind coil_link_serdes coil_link_serdes_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_req    (mode_req),
  .mode_o      (mode_o),
  .tx_take     (tx_take),
  .coil_data_o (coil_data_o),
  .coil_clk_o  (coil_clk_o),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o),
  .rx_valid    (rx_valid)
);

// File: tb/tb_coil_link_serdes.sv
`timescale 1ns/1ps
module tb_coil_link_serdes;

  localparam int WW  = 32;
  localparam int LN  = 8;
  localparam int LAT = 2;
  localparam int NS  = WW / LN;
  localparam int NP  = NS + 1;
  localparam int NW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]    d_mode_req, p_mode_req, d_mode, p_mode;
  logic [WW-1:0] d_word, p_word, d_rxw, p_rxw;
  logic          d_take, p_take, d_cko, p_cko, d_cki, p_cki;
  logic [LN-1:0] d_cdo, p_cdo, d_cdi, p_cdi;
  logic          d_txen, p_txen, d_rxen, p_rxen, d_rxv, p_rxv;

  logic [LN-1:0] d2p_data, p2d_data;
  logic          d2p_clk, p2d_clk;
  logic          kill_mark = 1'b0;

  int  cyc;
  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  coil_link_serdes #(.WORD_W(WW), .LANES(LN), .RX_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .mode_req(d_mode_req), .mode_o(d_mode),
    .tx_word(d_word), .tx_take(d_take), .coil_data_o(d_cdo), .coil_clk_o(d_cko),
    .coil_data_i(d_cdi), .coil_clk_i(d_cki), .tx_en_o(d_txen), .rx_en_o(d_rxen),
    .rx_word(d_rxw), .rx_valid(d_rxv)
  );

  coil_link_serdes #(.WORD_W(WW), .LANES(LN), .RX_LAT(LAT)) peer (
    .clk(clk), .rst(rst), .mode_req(p_mode_req), .mode_o(p_mode),
    .tx_word(p_word), .tx_take(p_take), .coil_data_o(p_cdo), .coil_clk_o(p_cko),
    .coil_data_i(p_cdi), .coil_clk_i(p_cki), .tx_en_o(p_txen), .rx_en_o(p_rxen),
    .rx_word(p_rxw), .rx_valid(p_rxv)
  );

  // One register of link flight time in each direction.
  always @(posedge clk) begin
    if (rst) begin
      d2p_data <= '0; d2p_clk <= 1'b0; p2d_data <= '0; p2d_clk <= 1'b0;
    end else begin
      d2p_data <= d_cdo; d2p_clk <= d_cko & ~kill_mark;
      p2d_data <= p_cdo; p2d_clk <= p_cko;
    end
  end
  assign p_cdi = d2p_data;
  assign p_cki = d2p_clk;
  assign d_cdi = p2d_data;
  assign d_cki = p2d_clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_take(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3*NP && !got; i++) begin
      step();
      if (d_take) got = 1'b1;
    end
  endtask

  task automatic both_idle();
    d_mode_req = 2'b00; p_mode_req = 2'b00;
    step(); step();
  endtask

  task automatic t_reset();
    rst = 1'b1; d_mode_req = 2'b00; p_mode_req = 2'b00; d_word = '0; p_word = '0;
    repeat (3) step();
    chk(d_mode == 2'b00, "R2 reset mode idle", d_mode, 0);
    chk(d_cdo == '0 && !d_cko && !d_take, "R8 reset outputs quiet", {d_cdo, d_cko, d_take}, 0);
    chk(!d_rxv && d_rxw == '0, "R6 reset receive state", {d_rxv, d_rxw}, 0);
    rst = 1'b0;
  endtask

  task automatic t_phase();
    for (int k = 0; k < 3*NP; k++) begin
      chk(d_txen == ((cyc % NP) < NS), "R1 tx strobe pattern", d_txen, ((cyc % NP) < NS));
      chk(d_rxen == (((cyc + NP - LAT) % NP) < NS), "R5 rx strobe delayed", d_rxen,
          (((cyc + NP - LAT) % NP) < NS));
      step();
    end
  endtask

  task automatic t_mode();
    for (int c = 0; c < 4; c++) begin
      d_mode_req = 2'(c);
      step();
      chk(d_mode == ((c == 3) ? 2'b00 : 2'(c)), "R2 mode after one cycle", d_mode,
          (c == 3) ? 0 : c);
    end
    both_idle();
  endtask

  task automatic t_tx_frame(input logic [WW-1:0] w);
    bit got;
    logic [WW-1:0] nw;
    p_mode_req = 2'b00;
    d_word = w; d_mode_req = 2'b01;
    wait_take(got);
    chk(got, "R3 take seen", got, 1);
    chk((cyc % NP) == 1, "R3 take phase", cyc % NP, 1);
    chk(d_cdo == w[LN-1:0], "R3 slice 0", d_cdo, w[LN-1:0]);
    chk(d_cko, "R3 marker with slice 0", d_cko, 1);
    nw = ~w;
    d_word = nw;
    for (int s = 1; s < NS; s++) begin
      step();
      chk(d_cdo == w[s*LN +: LN], "R3 slice order", d_cdo, w[s*LN +: LN]);
      chk(!d_cko, "R3 marker only once", d_cko, 0);
    end
    step();
    chk(d_cdo == '0 && !d_cko && !d_take, "R4 turnaround quiet", {d_cdo, d_cko}, 0);
    step();
    chk(d_take && d_cdo == nw[LN-1:0], "R3 next word sampled", d_cdo, nw[LN-1:0]);
    both_idle();
  endtask

  task automatic t_quiet();
    for (int m = 0; m < 2; m++) begin
      d_mode_req = (m == 0) ? 2'b00 : 2'b10;
      d_word = 32'hFFFF_FFFF;
      step(); step();
      for (int i = 0; i < 2*NP; i++) begin
        step();
        chk(d_cdo == '0 && !d_cko && !d_take, "R8 non-transmit quiet", {d_cdo, d_cko, d_take}, 0);
      end
    end
    both_idle();
  endtask

  task automatic t_loopback();
    logic [WW-1:0] wl [NW];
    int sent, recv;
    wl[0] = '0; wl[1] = '1; wl[2] = 32'hA5A5_5A5A; wl[3] = 32'h0403_0201;
    for (int i = 4; i < NW; i++) wl[i] = $urandom;
    both_idle();
    sent = 0; recv = 0;
    d_word = wl[0]; d_mode_req = 2'b01; p_mode_req = 2'b10;
    for (int i = 0; i < 30*NP && recv < NW; i++) begin
      step();
      if (d_take) begin
        sent++;
        d_word = (sent < NW) ? wl[sent] : wl[NW-1];
      end
      if (p_rxv) begin
        chk(p_rxw == wl[recv], "R11 word intact and in order", p_rxw, wl[recv]);
        chk((cyc % NP) == ((NS + LAT) % NP), "R6 valid phase", cyc % NP, (NS + LAT) % NP);
        recv++;
      end
    end
    chk(recv == NW, "R11 word count", recv, NW);
    both_idle();
  endtask

  task automatic t_no_marker(input logic [WW-1:0] x);
    logic [WW-1:0] prev;
    int cnt;
    bit got;
    both_idle();
    kill_mark = 1'b1;
    d_word = x; d_mode_req = 2'b01; p_mode_req = 2'b10;
    prev = p_rxw; cnt = 0;
    for (int i = 0; i < 3*NP; i++) begin
      step();
      if (p_rxv) cnt++;
    end
    chk(cnt == 0, "R7 no marker no word", cnt, 0);
    chk(p_rxw == prev, "R7 word held without marker", p_rxw, prev);
    kill_mark = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 3*NP && !got; i++) begin
      step();
      if (p_rxv) got = 1'b1;
    end
    chk(got && p_rxw == x, "R7 delivery after marker returns", p_rxw, x);
    both_idle();
  endtask

  task automatic t_rx_ignore(input logic [WW-1:0] y);
    logic [WW-1:0] prev_p, prev_d;
    int cnt;
    both_idle();
    d_word = y; p_word = ~y;
    for (int m = 0; m < 2; m++) begin
      d_mode_req = 2'b01;
      p_mode_req = (m == 0) ? 2'b00 : 2'b01;
      prev_p = p_rxw; prev_d = d_rxw; cnt = 0;
      for (int i = 0; i < 3*NP; i++) begin
        step();
        if (p_rxv || d_rxv) cnt++;
      end
      chk(cnt == 0, "R9 no valid outside receive", cnt, 0);
      chk(p_rxw == prev_p && d_rxw == prev_d, "R9 word unchanged outside receive", p_rxw, prev_p);
    end
    both_idle();
  endtask

  task automatic t_midframe(input logic [WW-1:0] z);
    bit got;
    both_idle();
    d_word = z; d_mode_req = 2'b01;
    wait_take(got);
    chk(got && d_cdo == z[LN-1:0], "R10 frame started", d_cdo, z[LN-1:0]);
    d_mode_req = 2'b00;
    step();
    chk(d_mode == 2'b00, "R2 leave transmit one cycle", d_mode, 0);
    chk(d_cdo == z[2*LN-1:LN], "R10 slice in flight", d_cdo, z[2*LN-1:LN]);
    step();
    chk(d_cdo == '0 && !d_cko, "R10 drive stops", d_cdo, 0);
    for (int i = 0; i < NP && (cyc % NP) != 2; i++) step();
    d_mode_req = 2'b01;
    got = 1'b0;
    for (int i = 0; i < 2*NP && !got; i++) begin
      step();
      if (d_take) got = 1'b1;
      else chk(d_cdo == '0 && !d_cko, "R10 late entry stays quiet", d_cdo, 0);
    end
    chk(got && (cyc % NP) == 1 && d_cdo == z[LN-1:0], "R10 waits for frame start", d_cdo, z[LN-1:0]);
    both_idle();
  endtask

  task automatic t_reverse(input logic [WW-1:0] v);
    bit got;
    both_idle();
    p_word = v; p_mode_req = 2'b01; d_mode_req = 2'b10;
    got = 1'b0;
    for (int i = 0; i < 4*NP && !got; i++) begin
      step();
      if (d_rxv) got = 1'b1;
    end
    chk(got && d_rxw == v, "R11 reverse direction", d_rxw, v);
    both_idle();
  endtask

  initial begin
    t_reset();
    t_phase();
    t_mode();
    t_tx_frame(32'h8877_6655);
    t_quiet();
    t_loopback();
    t_no_marker(32'hC0DE_1234);
    t_rx_ignore(32'h3C3C_F00F);
    t_midframe(32'h1122_3344);
    t_reverse(32'h5A69_96A5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 act=timeout exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule